// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves data between two parallel ports, A and B, in either direction. Each direction has a storage register with its own clock. It also has a select that picks what that direction sends: the live value on the opposite bus, or the value captured in its register. Each direction also has an output enable. The A-to-B enable is active high and the B-to-A enable is active low.

Each bus is split into an input vector, an output vector and a per-bit output-enable vector, so the block itself stays free of tri-states. Pin-level resolution and bus-hold belong to the surroundings. Typical uses are plain pass-through, storing a bus value for later replay, and replaying a stored value while the other side keeps running live. A fourth use enables both directions in live mode, so that each bus reinforces the other and the pair keeps its last value once all other drivers let go.

Every rising edge on a direction's clock captures the source bus into that direction's register, whatever the select and enable settings are. The output selector carries a consensus term, so a change of select leaves the output steady when live and stored data agree.

Top module: `bidir_xcvr_reg`

## Requirements
- R1: On each rising edge of `clk_ab` with `rst` low, the A-to-B register takes the value of `a_in`, whatever `sel_ab` and `oe_ab` are.
- R2: On each rising edge of `clk_ba` with `rst` low, the B-to-A register takes the value of `b_in`, whatever `sel_ba` and `oe_ba_n` are.
- R3: With a select at 0 (live) and its direction enabled, the output follows the opposite bus input in the same cycle: `b_out` equals `a_in`, and `a_out` equals `b_in`.
- R4: With a select at 1 (stored) and its direction enabled, the output equals the register value, and it shows a new capture straight after the capturing edge.
- R5: When `oe_ab` is 1, `b_oe` is all ones. When `oe_ab` is 0, `b_oe` is all zeros and `b_out` is all zeros.
- R6: When `oe_ba_n` is 0, `a_oe` is all ones. When `oe_ba_n` is 1, `a_oe` is all zeros and `a_out` is all zeros.
- R7: `rst` is synchronous and active high. A rising edge of a direction's clock while `rst` is 1 clears only that direction's register to zero. The register of the other direction, whose clock does not rise, keeps its value.
- R8: When the live input and the stored value of a direction are equal, toggling that direction's select does not change its output.
- R9: With both selects at 0 and both directions enabled, once all external drivers release the buses, both buses keep the last driven value. A new value driven on either bus then appears on the other.
- R10: With both selects at 1, clocks on separate edges load the two registers with different data. With both selects at 0, both clocks may rise on the same edge and both registers still capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock for the A-to-B register |
| clk_ba | input | 1 | Capture clock for the B-to-A register |
| rst | input | 1 | Synchronous active-high clear, sampled on each direction's clock |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| oe_ab | input | 1 | A-to-B drive enable, active high |
| oe_ba_n | input | 1 | B-to-A drive enable, active low |
| a_in | input | WIDTH | Sensed value of bus A |
| a_out | output | WIDTH | Value driven onto bus A |
| a_oe | output | WIDTH | Per-bit drive enable for bus A |
| b_in | input | WIDTH | Sensed value of bus B |
| b_out | output | WIDTH | Value driven onto bus B |
| b_oe | output | WIDTH | Per-bit drive enable for bus B |

## Verification
A capture in one direction can land in the same cycle as the loop-back or live transfer in the other. The bench pulses `clk_ab` and `clk_ba` on the same edge while the buses reinforce each other through the live path. A behavioural model samples the resolved bus value just ahead of the edge, and the bench compares each captured value against that model. A second coincidence is a capture made while the same direction is in stored mode. Here the output has to change right after that edge, and the bench judges it against the model value in that same cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_DEF_WIDTH = 8;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;
endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int unsigned WIDTH = xcvr_pkg::XCVR_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] CLEAR = '0;

  // Always loads: no enable path, so select and output enable cannot block a capture.
  always_ff @(posedge clk) begin
    if (rst) q <= CLEAR;
    else     q <= d;
  end

  // R1 and R2: every edge out of reset captures the bus
  p_capture_r1_r2: assert property (@(posedge clk) !rst |=> q == $past(d));
  // R7: an edge under reset clears the register
  p_clear_r7: assert property (@(posedge clk) rst |=> q == CLEAR);
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
  parameter int unsigned WIDTH = xcvr_pkg::XCVR_DEF_WIDTH
) (
  input  logic             en,
  input  xcvr_pkg::src_e   src,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] out,
  output logic [WIDTH-1:0] oe
);
  import xcvr_pkg::*;

  logic [WIDTH-1:0] m_st;
  logic [WIDTH-1:0] m_lv;
  logic [WIDTH-1:0] pick;

  // Sum-of-products selector with consensus term (stored & live): when both
  // sources agree, the output holds through a select change.
  always_comb begin
    m_st = {WIDTH{src == SRC_STORED}};
    m_lv = ~m_st;
    pick = (stored & m_st) | (live & m_lv) | (stored & live);
    out  = en ? pick : '0;
    oe   = {WIDTH{en}};
  end

  always_comb begin
    if (en && src == SRC_LIVE)   p_live_r3:   assert (out == live);
    if (en && src == SRC_STORED) p_stored_r4: assert (out == stored);
    if (en && live == stored)    p_steady_r8: assert (out == live);
    if (!en)                     p_idle_r5_r6: assert (out == '0 && oe == '0);
  end
endmodule

// File: rtl/bidir_xcvr_reg.sv
module bidir_xcvr_reg #(
  parameter int unsigned WIDTH = xcvr_pkg::XCVR_DEF_WIDTH
) (
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             rst,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic             oe_ab,
  input  logic             oe_ba_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe
);
  import xcvr_pkg::*;

  logic [WIDTH-1:0] hold_ab;
  logic [WIDTH-1:0] hold_ba;
  logic             en_ab;
  logic             en_ba;
  src_e             src_ab;
  src_e             src_ba;

  // Opposite enable polarities: both directions may be on together.
  always_comb begin
    en_ab  = oe_ab;
    en_ba  = ~oe_ba_n;
    src_ab = src_e'(sel_ab);
    src_ba = src_e'(sel_ba);
  end

  xcvr_capture #(.WIDTH(WIDTH)) u_cap_ab (
    .clk (clk_ab), .rst (rst), .d (a_in), .q (hold_ab)
  );

  xcvr_capture #(.WIDTH(WIDTH)) u_cap_ba (
    .clk (clk_ba), .rst (rst), .d (b_in), .q (hold_ba)
  );

  xcvr_drive #(.WIDTH(WIDTH)) u_drv_b (
    .en (en_ab), .src (src_ab), .live (a_in), .stored (hold_ab),
    .out (b_out), .oe (b_oe)
  );

  xcvr_drive #(.WIDTH(WIDTH)) u_drv_a (
    .en (en_ba), .src (src_ba), .live (b_in), .stored (hold_ba),
    .out (a_out), .oe (a_oe)
  );

  // R5 and R6: the enable vectors sit on opposite polarities of their controls
  always_comb begin
    p_pol_r5: assert (b_oe == {WIDTH{oe_ab}});
    p_pol_r6: assert (a_oe == {WIDTH{!oe_ba_n}});
  end
endmodule

// File: tb/bidir_xcvr_reg_tb.sv
`timescale 1ns/1ps
module bidir_xcvr_reg_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         clk_ab = 1'b0, clk_ba = 1'b0, rst = 1'b1;
  logic         sel_ab = 1'b0, sel_ba = 1'b0, oe_ab = 1'b0, oe_ba_n = 1'b1;
  logic [W-1:0] bus_a = '0, bus_b = '0, ext_a = '0, ext_b = '0;
  bit           ext_a_en = 1'b1, ext_b_en = 1'b1;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic [W-1:0] mdl_ab = '0, mdl_ba = '0;
  int           n_cmp = 0, n_bad = 0;

  bidir_xcvr_reg #(.WIDTH(W)) u_dut (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .a_in(bus_a), .a_out(a_out), .a_oe(a_oe),
    .b_in(bus_b), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // Bus resolution wrapper: external driver wins, else block driver, else hold.
  task automatic settle();
    for (int i = 0; i < 4; i++) begin
      #1;
      if (ext_a_en) bus_a = ext_a; else if (a_oe[0]) bus_a = a_out;
      if (ext_b_en) bus_b = ext_b; else if (b_oe[0]) bus_b = b_out;
    end
  endtask

  task automatic compare(input string tag);
    logic [W-1:0] eb, ea;
    eb = oe_ab ? (sel_ab ? mdl_ab : bus_a) : '0;
    ea = !oe_ba_n ? (sel_ba ? mdl_ba : bus_b) : '0;
    chk(tag, "b_out", b_out, eb);
    chk(tag, "b_oe", b_oe, {W{oe_ab}});
    chk(tag, "a_out", a_out, ea);
    chk(tag, "a_oe", a_oe, {W{!oe_ba_n}});
  endtask

  task automatic cyc(input bit pab, input bit pba, input string tag);
    @(posedge clk);
    if (pab) mdl_ab = rst ? '0 : bus_a;
    if (pba) mdl_ba = rst ? '0 : bus_b;
    clk_ab = pab;
    clk_ba = pba;
    settle();
    compare(tag);
    @(negedge clk);
    clk_ab = 1'b0;
    clk_ba = 1'b0;
    settle();
    compare(tag);
  endtask

  task automatic drive(input logic [W-1:0] va, input logic [W-1:0] vb);
    ext_a = va; ext_b = vb; ext_a_en = 1'b1; ext_b_en = 1'b1;
    settle();
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R7: reset state, both registers cleared, stored replay shows zero
    drive(8'hA5, 8'h3C);
    sel_ab = 1'b1; sel_ba = 1'b1; oe_ab = 1'b1; oe_ba_n = 1'b0;
    cyc(1, 1, "R7");
    cyc(1, 1, "R7");
    chk("R7", "b_out", b_out, 8'h00);
    chk("R7", "a_out", a_out, 8'h00);
    rst = 1'b0;

    // R3 live pass-through A to B with A side off (R6), several patterns
    sel_ab = 1'b0; oe_ab = 1'b1; oe_ba_n = 1'b1;
    for (int v = 0; v < 6; v++) begin
      drive(8'(v * 37 + 1), 8'(v * 11));
      cyc(0, 0, "R3");
      chk("R3", "b_out", b_out, 8'(v * 37 + 1));
      chk("R6", "a_oe", a_oe, 8'h00);
    end

    // R1: capture while disabled and in live mode, then replay stored (R4)
    oe_ab = 1'b0;
    drive(8'h5A, 8'h00);
    cyc(1, 0, "R1");
    chk("R5", "b_out", b_out, 8'h00);
    drive(8'h99, 8'h00);
    sel_ab = 1'b1; oe_ab = 1'b1;
    settle();
    chk("R4", "b_out", b_out, 8'h5A);
    cyc(0, 0, "R4");

    // R4: capture in stored mode shows right after the edge
    drive(8'h42, 8'h00);
    cyc(1, 0, "R4");
    chk("R4", "b_out", b_out, 8'h42);

    // R2: B-to-A capture while disabled, then replay with active-low enable (R6)
    oe_ab = 1'b0;
    sel_ba = 1'b0; oe_ba_n = 1'b1;
    drive(8'h00, 8'hC3);
    cyc(0, 1, "R2");
    chk("R6", "a_out", a_out, 8'h00);
    drive(8'h00, 8'h11);
    sel_ba = 1'b1; oe_ba_n = 1'b0;
    settle();
    chk("R2", "a_out", a_out, 8'hC3);
    chk("R6", "a_oe", a_oe, 8'hFF);
    cyc(0, 0, "R2");

    // R10: stored mode, staggered clocks load differing data
    sel_ab = 1'b1; sel_ba = 1'b1; oe_ab = 1'b1; oe_ba_n = 1'b0;
    drive(8'h1E, 8'hE1);
    cyc(1, 0, "R10");
    drive(8'h2D, 8'hD2);
    cyc(0, 1, "R10");
    chk("R10", "b_out", b_out, 8'h1E);
    chk("R10", "a_out", a_out, 8'hD2);

    // R10: live mode, simultaneous clocks, then replay both
    sel_ab = 1'b0; sel_ba = 1'b0;
    drive(8'h6B, 8'hB6);
    cyc(1, 1, "R10");
    sel_ab = 1'b1; sel_ba = 1'b1;
    drive(8'h00, 8'h00);
    chk("R10", "b_out", b_out, 8'h6B);
    chk("R10", "a_out", a_out, 8'hB6);

    // R8: live equals stored, toggle select, output steady
    oe_ba_n = 1'b1;
    drive(8'h3F, 8'h00);
    cyc(1, 0, "R8");
    for (int i = 0; i < 4; i++) begin
      sel_ab = ~sel_ab;
      #1;
      chk("R8", "b_out", b_out, 8'h3F);
    end

    // R9: both live and enabled, buses hold after release
    sel_ab = 1'b0; sel_ba = 1'b0; oe_ab = 1'b1; oe_ba_n = 1'b0;
    ext_a = 8'h77; ext_a_en = 1'b1; ext_b_en = 1'b0;
    settle();
    chk("R9", "bus_b", bus_b, 8'h77);
    ext_a_en = 1'b0;
    settle();
    cyc(0, 0, "R9");
    chk("R9", "bus_a", bus_a, 8'h77);
    chk("R9", "bus_b", bus_b, 8'h77);
    // loop holds while both registers capture on one edge
    cyc(1, 1, "R9");
    ext_b = 8'h19; ext_b_en = 1'b1;
    settle();
    ext_b_en = 1'b0;
    settle();
    chk("R9", "bus_a", bus_a, 8'h19);
    chk("R9", "bus_b", bus_b, 8'h19);
    cyc(0, 0, "R9");
    sel_ab = 1'b1; sel_ba = 1'b1;
    settle();
    chk("R10", "b_out", b_out, 8'h77);
    chk("R10", "a_out", a_out, 8'h77);

    // R7: reset on one clock clears only that register
    drive(8'hF0, 8'h0F);
    cyc(1, 1, "R7");
    rst = 1'b1;
    cyc(1, 0, "R7");
    rst = 1'b0;
    settle();
    chk("R7", "b_out", b_out, 8'h00);
    chk("R7", "a_out", a_out, 8'h0F);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule